// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits beside an 8-bit CPU and keeps track of how the 64K address space is split into four 16K slots. It decodes I/O writes to two write-only paging ports. It holds the paging state in registers. For each CPU address it reports whether the addressed slot holds ROM, and if so which of two ROMs. Otherwise it reports which of eight RAM banks is mapped there. It also flags accesses to the slower, shared banks 4 to 7, and it gives the bank that the video fetcher shows as the screen.

The primary port selects the RAM bank in the top slot, the screen bank and the ROM. It also carries a sticky lock bit. In normal mode, slots 1 and 2 always hold banks 5 and 2. The extended port can switch to a special mode that replaces the whole map with one of four fixed all-RAM layouts. Both ports use partial address decoding. Mapping outputs are combinational from the registered state.

Top module: `bank_pager`

## Requirements
- R1: After reset the map is in normal mode: slot 0 holds ROM 0, slot 3 holds bank 0, the screen is bank 5 and the lock is released.
- R2: A write reaches the primary port only when address bit 1 is 0, bit 14 is 1 and bit 15 is 0. All other address bits are ignored.
- R3: A write reaches the extended port only when address bit 1 is 0, bit 12 is 1 and bits 13, 14 and 15 are 0.
- R4: Primary data bits 2..0 select the RAM bank seen at 0xC000 to 0xFFFF in normal mode.
- R5: Primary data bit 3 selects the screen bank: 0 gives bank 5 and 1 gives bank 7.
- R6: Primary data bit 4 selects which ROM (0 or 1) appears at 0x0000 to 0x3FFF in normal mode.
- R7: In normal mode, 0x4000 to 0x7FFF maps to bank 5 and 0x8000 to 0xBFFF maps to bank 2, whatever the screen bit holds.
- R8: Extended data bit 0 = 1 selects special mode. Bits 2..1 (value 0 to 3) then give slots 0 to 3 as {0,1,2,3}, {4,5,6,7}, {4,5,6,3} or {4,7,6,3}. No slot holds ROM in special mode.
- R9: Writing primary bit 5 as 1 sets a lock. Later writes to either port are ignored until reset.
- R10: The contended flag is 1 exactly when the addressed slot holds RAM bank 4, 5, 6 or 7.
- R11: State changes only on the clock edge that samples the I/O-write strobe high. Address and data without the strobe change nothing.
- R12: Writing extended bit 0 as 0 restores the normal map from the primary register, which special mode left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address: port address on I/O cycles, memory address otherwise |
| cpu_wdata | input | 8 | CPU write data |
| io_wr | input | 1 | I/O-write strobe, sampled on the rising clock edge |
| slot_is_rom | output | 1 | Addressed slot holds ROM |
| slot_rom_id | output | 1 | ROM number when slot_is_rom, else 0 |
| slot_bank | output | 3 | RAM bank of the addressed slot, 0 when ROM |
| slot_contended | output | 1 | Addressed slot holds bank 4 to 7 |
| screen_bank | output | 3 | Bank shown as the screen (5 or 7) |

## Verification
The hardest state to reach is one where a locked primary register must stay frozen against a write to the extended port. The bench sets the lock with a write that also changes the top bank. It then tries both ports and probes both the top slot and slot 0. Finally it pulses reset and shows that a fresh primary write is accepted again. Partial decoding is checked with addresses that differ from a matching one in a single decoded bit, and with a matching address whose undecoded bits differ from the usual port value.

// File: rtl/pgc_pkg.sv
// Shared constants and types for the paging controller.
// Assumes a 16-bit CPU address space split into four 16K slots.
package pgc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int BANK_W = 3;
    localparam int SLOT_W = 2;

    // Port decode masks: only bits set in the mask take part in the match.
    localparam logic [ADDR_W-1:0] PRI_MASK  = 16'hC002;
    localparam logic [ADDR_W-1:0] PRI_MATCH = 16'h4000;
    localparam logic [ADDR_W-1:0] EXT_MASK  = 16'hF002;
    localparam logic [ADDR_W-1:0] EXT_MATCH = 16'h1000;

    // Primary data bit positions.
    localparam int PRI_SCR_BIT  = 3;
    localparam int PRI_ROM_BIT  = 4;
    localparam int PRI_LOCK_BIT = 5;

    // Fixed banks in normal mode and screen choices.
    localparam logic [BANK_W-1:0] NORM_SLOT1_BANK = 3'd5;
    localparam logic [BANK_W-1:0] NORM_SLOT2_BANK = 3'd2;
    localparam logic [BANK_W-1:0] SCR_NORMAL_BANK = 3'd5;
    localparam logic [BANK_W-1:0] SCR_SHADOW_BANK = 3'd7;

    typedef struct packed {
        logic              lock;
        logic              rom;
        logic              scr;
        logic [BANK_W-1:0] page;
        logic              special;
        logic [1:0]        cfg;
    } pgc_state_t;

    // Bank held by a slot in one of the four all-RAM layouts.
    function automatic logic [BANK_W-1:0] special_bank(input logic [1:0] cfg,
                                                      input logic [SLOT_W-1:0] slot);
        logic [BANK_W-1:0] b;
        case (slot)
            2'd0: b = (cfg == 2'd0) ? 3'd0 : 3'd4;
            2'd1: b = (cfg == 2'd0) ? 3'd1 : ((cfg == 2'd3) ? 3'd7 : 3'd5);
            2'd2: b = (cfg == 2'd0) ? 3'd2 : 3'd6;
            default: b = (cfg == 2'd1) ? 3'd7 : 3'd3;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/pgc_port_match.sv
// Partial address decoder for one I/O port.
// Assumes MASK marks the decoded bits and MATCH their required values.
module pgc_port_match
    import pgc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MASK  = '0,
    parameter logic [ADDR_W-1:0] MATCH = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Compare only the decoded bits.
    assign hit = ((addr & MASK) == (MATCH & MASK));
endmodule

// File: rtl/pgc_state_regs.sv
// Paging state registers for the primary and extended ports.
// Assumes hit inputs are mutually exclusive. The lock freezes both ports until reset.
module pgc_state_regs
    import pgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              pri_hit,
    input  logic              ext_hit,
    input  logic [DATA_W-1:0] wdata,
    output pgc_state_t        state
);
    pgc_state_t st_q;
    logic       unused_bits;

    assign unused_bits = ^{wdata[DATA_W-1:PRI_LOCK_BIT+1]};

    // Load the port registers on accepted writes, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (io_wr && !st_q.lock) begin
            if (pri_hit) begin
                st_q.page <= wdata[BANK_W-1:0];
                st_q.scr  <= wdata[PRI_SCR_BIT];
                st_q.rom  <= wdata[PRI_ROM_BIT];
                st_q.lock <= wdata[PRI_LOCK_BIT];
            end
            if (ext_hit) begin
                st_q.special <= wdata[0];
                st_q.cfg     <= wdata[2:1];
            end
        end
    end

    assign state = st_q;
endmodule

// File: rtl/pgc_slot_map.sv
// Translates the slot of a CPU address into ROM or RAM bank and contention flag.
// Purely combinational from the registered paging state.
module pgc_slot_map
    import pgc_pkg::*;
(
    input  pgc_state_t        state,
    input  logic [SLOT_W-1:0] slot,
    output logic              is_rom,
    output logic              rom_id,
    output logic [BANK_W-1:0] bank,
    output logic              contended,
    output logic [BANK_W-1:0] scr_bank
);
    // Pick ROM or RAM bank for the addressed slot.
    always_comb begin
        is_rom = 1'b0;
        rom_id = 1'b0;
        bank   = '0;
        if (state.special) begin
            bank = special_bank(state.cfg, slot);
        end else begin
            case (slot)
                2'd0: begin
                    is_rom = 1'b1;
                    rom_id = state.rom;
                end
                2'd1:    bank = NORM_SLOT1_BANK;
                2'd2:    bank = NORM_SLOT2_BANK;
                default: bank = state.page;
            endcase
        end
    end

    // Banks with the top bit set are shared with video.
    assign contended = !is_rom && bank[BANK_W-1];
    assign scr_bank  = state.scr ? SCR_SHADOW_BANK : SCR_NORMAL_BANK;
endmodule

// File: rtl/bank_pager.sv
// Banked memory paging controller top: two partially decoded write-only
// ports, sticky lock, normal and special slot maps.
// Assumes io_wr is high for one clock per I/O write.
module bank_pager
    import pgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              io_wr,
    output logic              slot_is_rom,
    output logic              slot_rom_id,
    output logic [2:0]        slot_bank,
    output logic              slot_contended,
    output logic [2:0]        screen_bank
);
    logic       pri_hit;
    logic       ext_hit;
    pgc_state_t pg_state;

    pgc_port_match #(.MASK(PRI_MASK), .MATCH(PRI_MATCH)) u_pri_dec (
        .addr (cpu_addr),
        .hit  (pri_hit)
    );

    pgc_port_match #(.MASK(EXT_MASK), .MATCH(EXT_MATCH)) u_ext_dec (
        .addr (cpu_addr),
        .hit  (ext_hit)
    );

    pgc_state_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .pri_hit (pri_hit),
        .ext_hit (ext_hit),
        .wdata   (cpu_wdata),
        .state   (pg_state)
    );

    pgc_slot_map u_map (
        .state     (pg_state),
        .slot      (cpu_addr[ADDR_W-1:ADDR_W-SLOT_W]),
        .is_rom    (slot_is_rom),
        .rom_id    (slot_rom_id),
        .bank      (slot_bank),
        .contended (slot_contended),
        .scr_bank  (screen_bank)
    );
endmodule

// File: rtl/bank_pager_chk.sv
// Property checker for bank_pager, attached by bind.
module bank_pager_chk
    import pgc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        io_wr,
    input logic [15:0] cpu_addr,
    input logic        slot_is_rom,
    input logic [2:0]  slot_bank,
    input logic        slot_contended,
    input logic [2:0]  screen_bank,
    input pgc_state_t  pg_state
);
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_state.lock |=> pg_state.lock);

    // R9
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_state.lock |=> $stable(pg_state));

    // R11
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable(pg_state));

    // R7
    normal_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_state.special && cpu_addr[15:14] == 2'd1) |-> (!slot_is_rom && slot_bank == 3'd5 && slot_contended));

    // R8
    special_no_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_state.special |-> !slot_is_rom);

    // R5
    screen_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (screen_bank == 3'd5) || (screen_bank == 3'd7));
endmodule

bind bank_pager bank_pager_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .io_wr          (io_wr),
    .cpu_addr       (cpu_addr),
    .slot_is_rom    (slot_is_rom),
    .slot_bank      (slot_bank),
    .slot_contended (slot_contended),
    .screen_bank    (screen_bank),
    .pg_state       (pg_state)
);

// File: tb/test_bank_pager.sv
`timescale 1ns/1ps
// Self-checking bench for bank_pager: vector table, then lock and reset tests.
module test_bank_pager;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        io_wr = 1'b0;
    logic        slot_is_rom;
    logic        slot_rom_id;
    logic [2:0]  slot_bank;
    logic        slot_contended;
    logic [2:0]  screen_bank;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    bank_pager i_bank_pager (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_addr       (cpu_addr),
        .cpu_wdata      (cpu_wdata),
        .io_wr          (io_wr),
        .slot_is_rom    (slot_is_rom),
        .slot_rom_id    (slot_rom_id),
        .slot_bank      (slot_bank),
        .slot_contended (slot_contended),
        .screen_bank    (screen_bank)
    );

    typedef struct packed {
        logic [15:0] wa;
        logic [7:0]  wd;
        logic        wr;
        logic [15:0] pa;
        logic        is_rom;
        logic        rom;
        logic [2:0]  bank;
        logic        cont;
        logic [2:0]  scr;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 22;
    localparam vec_t VEC [NVEC] = '{
        '{16'h0000, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 4'd1},  // R1 reset ROM 0
        '{16'h0000, 8'h00, 1'b0, 16'hC000, 1'b0, 1'b0, 3'd0, 1'b0, 3'd5, 4'd1},  // R1 top bank 0
        '{16'h7FFD, 8'h04, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd4, 1'b1, 3'd5, 4'd4},  // R4 bank 4
        '{16'h7FFD, 8'h13, 1'b1, 16'h0000, 1'b1, 1'b1, 3'd0, 1'b0, 3'd5, 4'd6},  // R6 ROM 1
        '{16'h0000, 8'h00, 1'b0, 16'hC123, 1'b0, 1'b0, 3'd3, 1'b0, 3'd5, 4'd4},  // R4 bank 3
        '{16'h7FFD, 8'h0E, 1'b1, 16'h4000, 1'b0, 1'b0, 3'd5, 1'b1, 3'd7, 4'd5},  // R5 shadow screen
        '{16'h0000, 8'h00, 1'b0, 16'h8000, 1'b0, 1'b0, 3'd2, 1'b0, 3'd7, 4'd7},  // R7 slot 2 fixed
        '{16'h7FFD, 8'h01, 1'b0, 16'hC000, 1'b0, 1'b0, 3'd6, 1'b1, 3'd7, 4'd11}, // R11 no strobe
        '{16'h3FFD, 8'h01, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd6, 1'b1, 3'd7, 4'd2},  // R2 bit14 low
        '{16'hBFFD, 8'h01, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd6, 1'b1, 3'd7, 4'd2},  // R2 bit15 high
        '{16'h7FFF, 8'h01, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd6, 1'b1, 3'd7, 4'd2},  // R2 bit1 high
        '{16'h4001, 8'h07, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd7, 1'b1, 3'd5, 4'd2},  // R2 alias hit
        '{16'h1FFD, 8'h01, 1'b1, 16'h0000, 1'b0, 1'b0, 3'd0, 1'b0, 3'd5, 4'd8},  // R8 layout 0
        '{16'h0000, 8'h00, 1'b0, 16'h4000, 1'b0, 1'b0, 3'd1, 1'b0, 3'd5, 4'd8},  // R8 layout 0
        '{16'h1FFD, 8'h03, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd7, 1'b1, 3'd5, 4'd10}, // R10 layout 1
        '{16'h1FFD, 8'h05, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd3, 1'b0, 3'd5, 4'd8},  // R8 layout 2
        '{16'h1FFD, 8'h07, 1'b1, 16'h4000, 1'b0, 1'b0, 3'd7, 1'b1, 3'd5, 4'd8},  // R8 layout 3
        '{16'h0000, 8'h00, 1'b0, 16'h8000, 1'b0, 1'b0, 3'd6, 1'b1, 3'd5, 4'd8},  // R8 layout 3
        '{16'h3FFD, 8'h00, 1'b1, 16'h0000, 1'b0, 1'b0, 3'd4, 1'b1, 3'd5, 4'd3},  // R3 bit13 high
        '{16'h1FFF, 8'h00, 1'b1, 16'h0000, 1'b0, 1'b0, 3'd4, 1'b1, 3'd5, 4'd3},  // R3 bit1 high
        '{16'h1000, 8'h00, 1'b1, 16'hC000, 1'b0, 1'b0, 3'd7, 1'b1, 3'd5, 4'd12}, // R12 back to normal
        '{16'h0000, 8'h00, 1'b0, 16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 4'd12}  // R12 ROM 0 again
    };

    // One bus cycle: drive address, data and strobe for a single clock.
    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic w);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        io_wr     = w;
        @(negedge clk);
        io_wr     = 1'b0;
    endtask

    // Probe one memory address and compare every mapping output.
    task automatic probe(input logic [15:0] a, input logic er, input logic eid,
                         input logic [2:0] eb, input logic ec, input logic [2:0] es,
                         input int req);
        cpu_addr = a;
        #1;
        n_checks++;
        if (slot_is_rom !== er || slot_rom_id !== eid || slot_bank !== eb ||
            slot_contended !== ec || screen_bank !== es) begin
            n_fail++;
            $display("FAIL R%0d addr=%h got rom=%b id=%b bank=%0d cont=%b scr=%0d exp rom=%b id=%b bank=%0d cont=%b scr=%0d",
                     req, a, slot_is_rom, slot_rom_id, slot_bank, slot_contended, screen_bank,
                     er, eid, eb, ec, es);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            bus(VEC[i].wa, VEC[i].wd, VEC[i].wr);
            probe(VEC[i].pa, VEC[i].is_rom, VEC[i].rom, VEC[i].bank, VEC[i].cont,
                  VEC[i].scr, int'(VEC[i].req));
        end

        // R9: lock set together with bank 1.
        bus(16'h7FFD, 8'h21, 1'b1);
        probe(16'hC000, 1'b0, 1'b0, 3'd1, 1'b0, 3'd5, 9);
        // R9: primary write ignored while locked.
        bus(16'h7FFD, 8'h1D, 1'b1);
        probe(16'hC000, 1'b0, 1'b0, 3'd1, 1'b0, 3'd5, 9);
        probe(16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 9);
        // R9: extended write ignored while locked.
        bus(16'h1FFD, 8'h03, 1'b1);
        probe(16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 9);

        // R1: reset releases lock and restores the default map.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'hC000, 1'b0, 1'b0, 3'd0, 1'b0, 3'd5, 1);
        bus(16'h7FFD, 8'h02, 1'b1);
        probe(16'hC000, 1'b0, 1'b0, 3'd2, 1'b0, 3'd5, 9);

        // R1: reset from special mode with shadow screen.
        bus(16'h7FFD, 8'h08, 1'b1);
        bus(16'h1FFD, 8'h03, 1'b1);
        probe(16'h0000, 1'b0, 1'b0, 3'd4, 1'b1, 3'd7, 8);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe(16'h0000, 1'b1, 1'b0, 3'd0, 1'b0, 3'd5, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule